// File: doc/BRIEF.md
# SDI Receive Line-Rate Mode Search Controller

This controller chooses the line-rate mode that an SDI receiver runs in. In automatic operation it walks through the candidate modes allowed by a six-bit enable mask. It stays on each candidate for a fixed dwell time. When the downstream good-data detector reports valid data, it settles on that mode and reports lock. A locked mode is released only after good data has been absent for a set number of consecutive cycles. A transceiver-ready flag arrives from another clock domain. While that flag is low, the search is held unlocked and does not step.

When automatic detection is off, the mode comes straight from a user-supplied code, and the locked output is held high. There are six mode codes. The two 12G sub-rates (integer and 1/1.001) have separate codes but share a single 12G locked flag. A dedicated search-restart input sends the search back to its starting candidate. It does so without the main reset. All inputs and outputs are plain control and status levels; there is no data stream and no handshake.

Top module: `sdi_mode_search`

## Requirements
- R1: Mode codes are 3'b000 HD, 3'b001 SD, 3'b010 3G, 3'b100 6G, 3'b101 12G integer rate and 3'b110 12G fractional rate. After reset in automatic operation, `mode_code` shows the lowest-numbered enabled mode and `locked` is low.
- R2: Mask bit 0 is HD, bit 1 SD, bit 2 3G, bit 3 6G, bit 4 12G integer and bit 5 12G fractional. While searching without good data, each candidate is held for exactly DWELL_CYC cycles. The search then moves to the next enabled bit in ascending order, wrapping from bit 5 to bit 0 and skipping disabled bits.
- R3: While searching, if `good_data` is high at a clock edge and the current candidate is enabled, `locked` rises after that edge and the mode stays put.
- R4: Once locked, `locked` falls after exactly LOSS_CYC consecutive cycles with `good_data` low. A shorter gap keeps the lock, and the mode code does not change while the lock holds.
- R5: `xcvr_ready` passes through a two-flop synchronizer. Three edges after it goes low, `locked` is low. While it stays low, the candidate does not step. Three edges after it returns high, the search resumes.
- R6: With `auto_en` low, `mode_code` equals `force_code` and `locked` is high, whatever the mask, the ready flag and good data.
- R7: The flags `is_hd`, `is_sd`, `is_3g`, `is_6g` and `is_12g` are at most one-hot. They are high only while `locked` is high and the mode code matches. `is_12g` covers both 3'b101 and 3'b110.
- R8: With an all-zero mask in automatic operation, `mode_code` is 3'b000 and `locked` stays low even when `good_data` is high.
- R9: A one-cycle pulse on `search_rst` drops the lock and returns the candidate to the lowest enabled mode, as a reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous reset, active high |
| search_rst | input | 1 | Synchronous restart of the mode search only |
| en_mask | input | 6 | Per-mode enable mask for the search |
| auto_en | input | 1 | High: automatic search; low: forced mode |
| force_code | input | 3 | Mode code applied when `auto_en` is low |
| xcvr_ready | input | 1 | Transceiver ready, asynchronous |
| good_data | input | 1 | Good-data indication for the current mode |
| mode_code | output | 3 | Current mode code |
| is_hd | output | 1 | Locked in HD |
| is_sd | output | 1 | Locked in SD |
| is_3g | output | 1 | Locked in 3G |
| is_6g | output | 1 | Locked in 6G |
| is_12g | output | 1 | Locked in either 12G rate |
| locked | output | 1 | Lock indication |

## Verification
The search is tested with three masks. A sparse mask (HD and 3G) shows skipping and wrap-around. A mask holding only the two 12G rates shows that both codes map to one flag. An empty mask shows that the controller never locks. On the good-data input, the bench compares a gap one cycle shorter than the loss window against one that lasts the full window. This separates a lock that ends too early from one that ends too late. The dwell time and the three-edge synchronizer latency are counted cycle by cycle, in both directions. The forced codes are tried against the flag decoding.

// File: rtl/sdi_mode_pkg.sv
package sdi_mode_pkg;
  localparam int unsigned NUM_MODES = 6;
  localparam int unsigned IDX_W = $clog2(NUM_MODES);

  typedef enum logic [2:0] {
    CODE_HD    = 3'b000,
    CODE_SD    = 3'b001,
    CODE_3G    = 3'b010,
    CODE_6G    = 3'b100,
    CODE_12G_I = 3'b101,
    CODE_12G_F = 3'b110
  } mode_code_e;

  typedef enum logic { ST_HUNT = 1'b0, ST_HOLD = 1'b1 } srch_state_e;

  function automatic logic [2:0] idx_to_code(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return CODE_HD;
      3'd1:    return CODE_SD;
      3'd2:    return CODE_3G;
      3'd3:    return CODE_6G;
      3'd4:    return CODE_12G_I;
      default: return CODE_12G_F;
    endcase
  endfunction
endpackage

// File: rtl/mode_sync2.sv
module mode_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mode_pick.sv
module mode_pick
  import sdi_mode_pkg::*;
#(
  parameter int unsigned N = NUM_MODES
) (
  input  logic [N-1:0]     mask,
  input  logic [IDX_W-1:0] from_idx,
  output logic             any_en,
  output logic [IDX_W-1:0] next_idx
);
  // Next enabled index strictly after from_idx, wrapping; itself if it is the only one.
  always_comb begin
    next_idx = '0;
    any_en   = 1'b0;
    for (int k = N; k >= 1; k--) begin
      int unsigned j;
      j = (int'(from_idx) + k) % N;
      if (mask[j]) begin
        next_idx = IDX_W'(j);
        any_en   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import sdi_mode_pkg::*;
#(
  parameter int unsigned DWELL_CYC = 16,
  parameter int unsigned LOSS_CYC  = 8,
  localparam int unsigned CNT_MAX  = (DWELL_CYC > LOSS_CYC) ? DWELL_CYC : LOSS_CYC,
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 rdy,
  input  logic                 good,
  input  logic [NUM_MODES-1:0] mask,
  input  logic                 any_en,
  input  logic [IDX_W-1:0]     first_idx,
  input  logic [IDX_W-1:0]     step_idx,
  output logic [IDX_W-1:0]     cur_idx,
  output logic                 hold
);
  localparam logic [CNT_W-1:0] DWELL_LAST = CNT_W'(DWELL_CYC - 1);
  localparam logic [CNT_W-1:0] LOSS_LAST  = CNT_W'(LOSS_CYC - 1);

  srch_state_e       st;
  logic [CNT_W-1:0]  cnt;
  logic              cur_en;

  assign cur_en = mask[cur_idx];
  assign hold   = (st == ST_HOLD);

  always_ff @(posedge clk) begin
    if (clr) begin
      st      <= ST_HUNT;
      cnt     <= '0;
      cur_idx <= any_en ? first_idx : '0;
    end else if (st == ST_HUNT) begin
      if (!any_en) begin
        cur_idx <= '0;
        cnt     <= '0;
      end else if (!rdy) begin
        cnt <= '0;
      end else if (!cur_en) begin
        cur_idx <= step_idx;
        cnt     <= '0;
      end else if (good) begin
        st  <= ST_HOLD;
        cnt <= '0;
      end else if (cnt == DWELL_LAST) begin
        cur_idx <= step_idx;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (!rdy || !cur_en) begin
        st  <= ST_HUNT;
        cnt <= '0;
      end else if (good) begin
        cnt <= '0;
      end else if (cnt == LOSS_LAST) begin
        st  <= ST_HUNT;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdi_mode_search.sv
module sdi_mode_search
  import sdi_mode_pkg::*;
#(
  parameter int unsigned DWELL_CYC = 16,
  parameter int unsigned LOSS_CYC  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       search_rst,
  input  logic [5:0] en_mask,
  input  logic       auto_en,
  input  logic [2:0] force_code,
  input  logic       xcvr_ready,
  input  logic       good_data,
  output logic [2:0] mode_code,
  output logic       is_hd,
  output logic       is_sd,
  output logic       is_3g,
  output logic       is_6g,
  output logic       is_12g,
  output logic       locked
);
  logic             rdy_s;
  logic             any_en, any_en_b;
  logic [IDX_W-1:0] first_idx, step_idx, cur_idx;
  logic             hold;

  mode_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .async_in(xcvr_ready), .sync_out(rdy_s)
  );

  mode_pick #(.N(NUM_MODES)) u_pick_first (
    .mask(en_mask), .from_idx(IDX_W'(NUM_MODES - 1)),
    .any_en(any_en), .next_idx(first_idx)
  );

  mode_pick #(.N(NUM_MODES)) u_pick_step (
    .mask(en_mask), .from_idx(cur_idx),
    .any_en(any_en_b), .next_idx(step_idx)
  );

  mode_fsm #(.DWELL_CYC(DWELL_CYC), .LOSS_CYC(LOSS_CYC)) u_fsm (
    .clk(clk), .clr(rst || search_rst || !auto_en), .rdy(rdy_s),
    .good(good_data), .mask(en_mask), .any_en(any_en && any_en_b),
    .first_idx(first_idx), .step_idx(step_idx),
    .cur_idx(cur_idx), .hold(hold)
  );

  always_comb begin
    mode_code = auto_en ? idx_to_code(cur_idx) : force_code;
    locked    = !auto_en || hold;
    is_hd     = locked && (mode_code == CODE_HD);
    is_sd     = locked && (mode_code == CODE_SD);
    is_3g     = locked && (mode_code == CODE_3G);
    is_6g     = locked && (mode_code == CODE_6G);
    is_12g    = locked && ((mode_code == CODE_12G_I) || (mode_code == CODE_12G_F));
  end
endmodule

// File: rtl/sdi_mode_search_chk.sv
module sdi_mode_search_chk (
  input logic       clk,
  input logic       rst,
  input logic       search_rst,
  input logic [5:0] en_mask,
  input logic       auto_en,
  input logic [2:0] force_code,
  input logic       xcvr_ready,
  input logic       good_data,
  input logic [2:0] mode_code,
  input logic       is_hd,
  input logic       is_sd,
  input logic       is_3g,
  input logic       is_6g,
  input logic       is_12g,
  input logic       locked
);
  assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_hd, is_sd, is_3g, is_6g, is_12g}) &&
    (!(is_hd || is_sd || is_3g || is_6g || is_12g) || locked));

  assert_forced_R6: assert property (@(posedge clk) disable iff (rst)
    !auto_en |-> (locked && mode_code == force_code));

  assert_empty_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (auto_en && en_mask == 6'b0 && $past(auto_en)) |-> (!locked && mode_code == 3'b000));

  assert_lock_needs_good_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(locked) && auto_en && $past(auto_en)) |-> $past(good_data));

  assert_mode_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked) && auto_en && $past(auto_en)) |-> $stable(mode_code));

  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (!xcvr_ready && $past(!xcvr_ready) && $past(!xcvr_ready, 2)) |=> (!locked || !auto_en));
endmodule

bind sdi_mode_search sdi_mode_search_chk u_chk (.*);

// File: tb/sdi_mode_search_tb.sv
module sdi_mode_search_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL = 16;
  localparam int LOSS  = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       search_rst = 1'b0;
  logic [5:0] en_mask = 6'b000101;
  logic       auto_en = 1'b1;
  logic [2:0] force_code = 3'b000;
  logic       xcvr_ready = 1'b1;
  logic       good_data = 1'b0;
  logic [2:0] mode_code;
  logic       is_hd, is_sd, is_3g, is_6g, is_12g, locked;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdi_mode_search #(.DWELL_CYC(DWELL), .LOSS_CYC(LOSS)) u_dut (
    .clk(clk), .rst(rst), .search_rst(search_rst), .en_mask(en_mask),
    .auto_en(auto_en), .force_code(force_code), .xcvr_ready(xcvr_ready),
    .good_data(good_data), .mode_code(mode_code), .is_hd(is_hd), .is_sd(is_sd),
    .is_3g(is_3g), .is_6g(is_6g), .is_12g(is_12g), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int flags();
    return {is_hd, is_sd, is_3g, is_6g, is_12g};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  // Returns number of edges until mode_code changes, sampled at negedge.
  task automatic edges_to_change(output int n);
    logic [2:0] prev;
    prev = mode_code;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (mode_code != prev) break;
    end
  endtask

  task automatic wait_mode(input logic [2:0] code);
    for (int i = 0; i < 200; i++) begin
      if (mode_code == code) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_and_dwell();
    int n;
    en_mask = 6'b000101; auto_en = 1'b1; good_data = 1'b0;
    do_reset();
    chk("R1 reset mode", mode_code, 3'b000);
    chk("R1 reset locked", locked, 0);
    edges_to_change(n);
    chk("R2 dwell length", n, DWELL);
    chk("R2 skip to 3G", mode_code, 3'b010);
    edges_to_change(n);
    chk("R2 wrap to HD", mode_code, 3'b000);
    chk("R2 dwell length again", n, DWELL);
  endtask

  task automatic t_lock_and_loss();
    int n;
    wait_mode(3'b010);
    good_data = 1'b1;
    @(negedge clk);
    chk("R3 locked", locked, 1);
    chk("R7 flag 3G only", flags(), 5'b00100);
    good_data = 1'b0;
    repeat (LOSS - 1) @(negedge clk);
    good_data = 1'b1;
    @(negedge clk);
    chk("R4 short gap keeps lock", locked, 1);
    chk("R4 mode held", mode_code, 3'b010);
    good_data = 1'b0;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!locked) break;
    end
    chk("R4 loss window", n, LOSS);
    chk("R7 flags clear unlocked", flags(), 0);
  endtask

  task automatic t_ready();
    logic [2:0] m;
    wait_mode(3'b000);
    good_data = 1'b1;
    @(negedge clk);
    chk("R3 locked HD", is_hd, 1);
    xcvr_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 still locked after 2", locked, 1);
    @(negedge clk);
    chk("R5 unlocked after 3", locked, 0);
    m = mode_code;
    good_data = 1'b0;
    repeat (DWELL * 3) @(negedge clk);
    chk("R5 no stepping", mode_code, m);
    chk("R5 held unlocked", locked, 0);
    good_data = 1'b1;
    xcvr_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 not yet relocked", locked, 0);
    @(negedge clk);
    chk("R5 relock after 3", locked, 1);
    good_data = 1'b0;
  endtask

  task automatic t_forced();
    auto_en = 1'b0; xcvr_ready = 1'b0; en_mask = 6'b0;
    force_code = 3'b101; @(negedge clk);
    chk("R6 forced code", mode_code, 3'b101);
    chk("R6 forced locked", locked, 1);
    chk("R7 12G integer flag", flags(), 5'b00001);
    force_code = 3'b110; @(negedge clk);
    chk("R7 12G fractional flag", flags(), 5'b00001);
    force_code = 3'b001; @(negedge clk);
    chk("R6 forced SD flag", flags(), 5'b01000);
    force_code = 3'b100; @(negedge clk);
    chk("R6 forced 6G flag", flags(), 5'b00010);
    xcvr_ready = 1'b1; auto_en = 1'b1;
  endtask

  task automatic t_empty_mask();
    int bad = 0;
    en_mask = 6'b0; good_data = 1'b1;
    do_reset();
    for (int i = 0; i < 3 * DWELL; i++) begin
      @(negedge clk);
      if (locked || mode_code != 3'b000) bad++;
    end
    chk("R8 empty mask never locks", bad, 0);
    good_data = 1'b0;
  endtask

  task automatic t_12g_and_restart();
    int n;
    en_mask = 6'b110000; good_data = 1'b0;
    do_reset();
    chk("R1 first enabled 12G", mode_code, 3'b101);
    edges_to_change(n);
    chk("R2 next 12G fractional", mode_code, 3'b110);
    good_data = 1'b1;
    @(negedge clk);
    chk("R7 12G fractional locked", flags(), 5'b00001);
    good_data = 1'b0;
    search_rst = 1'b1;
    @(negedge clk);
    search_rst = 1'b0;
    chk("R9 restart unlocked", locked, 0);
    chk("R9 restart first mode", mode_code, 3'b101);
  endtask

  initial begin
    t_reset_and_dwell();
    t_lock_and_loss();
    t_ready();
    t_forced();
    t_empty_mask();
    t_12g_and_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule